// File: doc/BRIEF.md
# Add/Subtract Unit with Relational Decode

This block adds or subtracts two WIDTH-bit operands on one shared ripple-carry chain of full adders. A single control input selects the operation. When it is high, the B operand is inverted bit by bit and a carry of one enters the lowest position, so the chain forms A + ~B + 1. The same binary result is correct whether the operands are read as signed or as unsigned values. The two readings differ only in how the top carry is interpreted.

From the result and the chain's top two carries, the block forms four condition flags: zero, negative, carry and overflow. A decoder then turns these flags into ten relational outputs. After a subtraction, those outputs give every signed and unsigned ordering of A against B. A parameter chooses between a one-cycle output register, which is the default, and a purely combinational path.

Top module: `addsub_cmp`

## Requirements
- R1: `sum_o` equals (a_i + b_i) mod 2^WIDTH when `sub_i` is 0, and (a_i − b_i) mod 2^WIDTH when `sub_i` is 1.
- R2: `zero_o` is 1 exactly when every bit of `sum_o` is 0.
- R3: `neg_o` equals bit WIDTH−1 of `sum_o`.
- R4: `carry_o` follows `sub_i`. On an add it is the carry out of the top full adder, which is 1 when a_i + b_i ≥ 2^WIDTH. On a subtract it is in borrow sense, which is 1 exactly when a_i < b_i as unsigned values.
- R5: `ovf_o` is 1 exactly when the true signed result lies outside −2^(WIDTH−1) to 2^(WIDTH−1)−1.
- R6: After a subtract, `lt_o`, `le_o`, `ge_o` and `gt_o` give a_i <, ≤, ≥ and > b_i with both operands read as two's complement. This holds at the most negative value too.
- R7: After a subtract, `ltu_o`, `leu_o`, `geu_o` and `gtu_o` give a_i <, ≤, ≥ and > b_i with both operands read as unsigned.
- R8: After a subtract, `eq_o` is 1 exactly when a_i equals b_i, and `ne_o` is its complement.
- R9: With REG_OUT=1, every output reflects the inputs sampled at the previous rising clock edge. While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| sub_i | input | 1 | 1 selects A − B, 0 selects A + B |
| sum_o | output | WIDTH | Result |
| zero_o | output | 1 | Result is all zeros |
| neg_o | output | 1 | Result sign bit |
| carry_o | output | 1 | Top carry on add, borrow on subtract |
| ovf_o | output | 1 | Signed overflow |
| eq_o | output | 1 | A equal to B |
| ne_o | output | 1 | A not equal to B |
| lt_o | output | 1 | Signed less than |
| le_o | output | 1 | Signed less or equal |
| ge_o | output | 1 | Signed greater or equal |
| gt_o | output | 1 | Signed greater than |
| ltu_o | output | 1 | Unsigned less than |
| leu_o | output | 1 | Unsigned less or equal |
| geu_o | output | 1 | Unsigned greater or equal |
| gtu_o | output | 1 | Unsigned greater than |

## Verification
The only state in the block is the output register, so any fault shows up at the ports one clock after the operands that expose it are applied.

A broken carry link misplaces `sum_o` for any operand pair whose carry crosses that link, for example −1 plus 1. A wrong carry polarity inverts every unsigned relation on the first subtract of distinct operands. A wrong overflow term changes the signed relations only when the operand signs differ and the difference wraps, so the most negative value against small positives is driven on purpose.

// File: rtl/addsub_cmp_pkg.sv
package addsub_cmp_pkg;

  // condition flags formed from one add or subtract
  typedef struct packed {
    logic z;
    logic n;
    logic c;
    logic v;
  } cc_t;

  // relational decode of A against B
  typedef struct packed {
    logic eq;
    logic ne;
    logic lt;
    logic le;
    logic ge;
    logic gt;
    logic ltu;
    logic leu;
    logic geu;
    logic gtu;
  } rel_t;

endpackage

// File: rtl/fa_cell.sv
module fa_cell (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  always_comb begin
    s  = ci ^ a ^ b;
    co = (ci & (a | b)) | (a & b);
  end
endmodule

// File: rtl/ripple_addsub.sv
module ripple_addsub #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  output logic [WIDTH-1:0] sum,
  output logic             co_top,
  output logic             ci_top
);
  logic [WIDTH:0]   chain;
  logic [WIDTH-1:0] b_eff;

  // subtract: invert B and feed the +1 through the bottom carry
  assign b_eff    = b ^ {WIDTH{sub}};
  assign chain[0] = sub;

  for (genvar k = 0; k < WIDTH; k++) begin : g_bit
    fa_cell u_fa (
      .a  (a[k]),
      .b  (b_eff[k]),
      .ci (chain[k]),
      .s  (sum[k]),
      .co (chain[k+1])
    );
  end

  assign co_top = chain[WIDTH];
  assign ci_top = chain[WIDTH-1];
endmodule

// File: rtl/cc_gen.sv
module cc_gen
  import addsub_cmp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] sum,
  input  logic             co_top,
  input  logic             ci_top,
  input  logic             sub,
  output cc_t              cc
);
  always_comb begin
    cc.z = ~|sum;
    cc.n = sum[WIDTH-1];
    // borrow sense on subtract: no carry out means A < B unsigned
    cc.c = co_top ^ sub;
    cc.v = co_top ^ ci_top;
  end
endmodule

// File: rtl/rel_decode.sv
module rel_decode
  import addsub_cmp_pkg::*;
(
  input  cc_t  cc,
  output rel_t rel
);
  logic slt;

  always_comb begin
    slt     = cc.n ^ cc.v;
    rel.eq  = cc.z;
    rel.ne  = ~cc.z;
    rel.lt  = slt;
    rel.le  = cc.z | slt;
    rel.ge  = ~slt;
    rel.gt  = ~(cc.z | slt);
    rel.ltu = cc.c;
    rel.leu = cc.c | cc.z;
    rel.geu = ~cc.c;
    rel.gtu = ~(cc.c | cc.z);
  end
endmodule

// File: rtl/addsub_cmp.sv
module addsub_cmp
  import addsub_cmp_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             zero_o,
  output logic             neg_o,
  output logic             carry_o,
  output logic             ovf_o,
  output logic             eq_o,
  output logic             ne_o,
  output logic             lt_o,
  output logic             le_o,
  output logic             ge_o,
  output logic             gt_o,
  output logic             ltu_o,
  output logic             leu_o,
  output logic             geu_o,
  output logic             gtu_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] sum_d;
  logic             co_top;
  logic             ci_top;
  cc_t              cc_d;
  rel_t             rel_d;

  logic [WIDTH-1:0] sum_q;
  cc_t              cc_q;
  rel_t             rel_q;

  ripple_addsub #(.WIDTH(WIDTH)) u_chain (
    .a      (a_i),
    .b      (b_i),
    .sub    (sub_i),
    .sum    (sum_d),
    .co_top (co_top),
    .ci_top (ci_top)
  );

  cc_gen #(.WIDTH(WIDTH)) u_cc (
    .sum    (sum_d),
    .co_top (co_top),
    .ci_top (ci_top),
    .sub    (sub_i),
    .cc     (cc_d)
  );

  rel_decode u_rel (
    .cc  (cc_d),
    .rel (rel_d)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sum_q <= '0;
        cc_q  <= '0;
        rel_q <= '0;
      end else begin
        sum_q <= sum_d;
        cc_q  <= cc_d;
        rel_q <= rel_d;
      end
    end
  end else begin : g_comb
    assign sum_q = sum_d;
    assign cc_q  = cc_d;
    assign rel_q = rel_d;
  end

  assign sum_o   = sum_q;
  assign zero_o  = cc_q.z;
  assign neg_o   = cc_q.n;
  assign carry_o = cc_q.c;
  assign ovf_o   = cc_q.v;
  assign eq_o    = rel_q.eq;
  assign ne_o    = rel_q.ne;
  assign lt_o    = rel_q.lt;
  assign le_o    = rel_q.le;
  assign ge_o    = rel_q.ge;
  assign gt_o    = rel_q.gt;
  assign ltu_o   = rel_q.ltu;
  assign leu_o   = rel_q.leu;
  assign geu_o   = rel_q.geu;
  assign gtu_o   = rel_q.gtu;

  if (REG_OUT) begin : g_chk
    assert_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> sum_o == ($past(sub_i) ? $past(a_i) - $past(b_i)
                                      : $past(a_i) + $past(b_i)));

    assert_zero_on_equal_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sub_i |=> zero_o == ($past(a_i) == $past(b_i)));

    assert_borrow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sub_i |=> carry_o == ($past(a_i) < $past(b_i)));

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!sub_i && (a_i[MSB] != b_i[MSB])) |=> !ovf_o);

    assert_signed_lt_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sub_i |=> lt_o == ($signed($past(a_i)) < $signed($past(b_i))));

    assert_unsigned_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sub_i |=> $countones({ltu_o, eq_o, gtu_o}) == 1);
  end
endmodule

// File: tb/addsub_cmp_bench.sv
module addsub_cmp_bench;
  localparam int W      = 8;
  localparam int T_CLK  = 10;
  localparam int N_RAND = 1500;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] a_i, b_i;
  logic         sub_i;
  logic [W-1:0] sum_o;
  logic zero_o, neg_o, carry_o, ovf_o;
  logic eq_o, ne_o, lt_o, le_o, ge_o, gt_o, ltu_o, leu_o, geu_o, gtu_o;

  int total = 0;
  int bad   = 0;

  addsub_cmp #(.WIDTH(W), .REG_OUT(1'b1)) u_addsub_cmp (
    .clk(clk), .rst_n(rst_n), .a_i(a_i), .b_i(b_i), .sub_i(sub_i),
    .sum_o(sum_o), .zero_o(zero_o), .neg_o(neg_o), .carry_o(carry_o),
    .ovf_o(ovf_o), .eq_o(eq_o), .ne_o(ne_o), .lt_o(lt_o), .le_o(le_o),
    .ge_o(ge_o), .gt_o(gt_o), .ltu_o(ltu_o), .leu_o(leu_o),
    .geu_o(geu_o), .gtu_o(gtu_o)
  );

  initial clk = 1'b0;
  always #(T_CLK/2) clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // apply one operation, wait through the output register, compare all
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic s);
    logic [W-1:0] es;
    logic         ec, ev;
    logic         slt, ult, eqv;
    @(negedge clk);
    a_i = a; b_i = b; sub_i = s;
    @(negedge clk);
    es = s ? a - b : a + b;
    if (s) begin
      ec = (a < b);
      ev = (a[W-1] != b[W-1]) && (es[W-1] != a[W-1]);
    end else begin
      ec = ({1'b0, a} + {1'b0, b}) >> W;
      ev = (a[W-1] == b[W-1]) && (es[W-1] != a[W-1]);
    end
    chk("R1", "sum", 32'(sum_o), 32'(es));
    chk("R2", "zero", 32'(zero_o), 32'(es == '0));
    chk("R3", "neg", 32'(neg_o), 32'(es[W-1]));
    chk("R4", "carry", 32'(carry_o), 32'(ec));
    chk("R5", "ovf", 32'(ovf_o), 32'(ev));
    if (s) begin
      slt = $signed(a) < $signed(b);
      ult = a < b;
      eqv = a == b;
      chk("R6", "lt", 32'(lt_o), 32'(slt));
      chk("R6", "le", 32'(le_o), 32'(slt | eqv));
      chk("R6", "ge", 32'(ge_o), 32'(!slt));
      chk("R6", "gt", 32'(gt_o), 32'(!(slt | eqv)));
      chk("R7", "ltu", 32'(ltu_o), 32'(ult));
      chk("R7", "leu", 32'(leu_o), 32'(ult | eqv));
      chk("R7", "geu", 32'(geu_o), 32'(!ult));
      chk("R7", "gtu", 32'(gtu_o), 32'(!(ult | eqv)));
      chk("R8", "eq", 32'(eq_o), 32'(eqv));
      chk("R8", "ne", 32'(ne_o), 32'(!eqv));
    end
  endtask

  task automatic test_reset();
    rst_n = 1'b0; a_i = 8'h5A; b_i = 8'h11; sub_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9", "reset sum", 32'(sum_o), 32'h0);
    chk("R9", "reset flags", 32'({zero_o, neg_o, carry_o, ovf_o}), 32'h0);
    chk("R9", "reset rel", 32'({eq_o, ne_o, lt_o, le_o, ge_o, gt_o,
                                 ltu_o, leu_o, geu_o, gtu_o}), 32'h0);
    rst_n = 1'b1;
  endtask

  task automatic test_latency();
    run_op(8'd5, 8'd3, 1'b0);
    @(negedge clk);
    a_i = 8'd1; b_i = 8'd1; sub_i = 1'b1;
    #1;
    chk("R9", "old sum held before edge", 32'(sum_o), 32'd8);
    @(negedge clk);
    chk("R9", "new sum after edge", 32'(sum_o), 32'd0);
    chk("R9", "eq after edge", 32'(eq_o), 32'd1);
  endtask

  task automatic test_add_patterns();
    run_op(8'd20, 8'd22, 1'b0);
    run_op(8'hFF, 8'h01, 1'b0);  // ripple through all bits, R4 carry
    run_op(8'h7F, 8'h01, 1'b0);  // R5 positive overflow
    run_op(8'h80, 8'h80, 1'b0);  // R5 negative overflow, zero result
    run_op(8'h80, 8'h7F, 1'b0);
  endtask

  task automatic test_sub_corners();
    logic [W-1:0] c [6] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'h81, 8'hFF};
    foreach (c[i])
      foreach (c[j])
        run_op(c[i], c[j], 1'b1);
  endtask

  task automatic test_random();
    for (int k = 0; k < N_RAND; k++)
      run_op(W'($urandom), W'($urandom), 1'($urandom));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    test_reset();
    test_latency();
    test_add_patterns();
    test_sub_corners();
    test_random();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule